// File: doc/BRIEF.md
# Memory Error Interrupt Controller

This block gathers error events reported by a memory controller and turns them into one masked interrupt plus a fatal-error line for a platform-level interrupt aggregator. Events come in as single-cycle pulses: a correctable ECC error, an uncorrectable ECC error, a per-lane parity error vector and an address error. Each pulse sets a sticky bit in a cause register. An enable register selects which causes reach the interrupt. ECC decoding happens upstream. Each ECC pulse carries the failing address and five data words, and the block keeps a copy of them for software.

Software reaches the block through a simple word-indexed register port. The port has a write strobe, an index, write data, and combinational read data for the index presented. Cause bits are cleared by writing ones to them. A summary bit records that some enabled cause has been active, and software clears it the same way. The parameter `LEGACY_CLEAR` selects a legacy mode. In that mode a write to the enable register also clears every cause bit written as one, and software then writes the enable value it wants back.

Top module: `memerr_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, and `irq_o` and `fatal_o` are low.
- R2: An event pulse sets its cause bit at the next rising edge. The cause register is at index 0. Its layout is: bit 0 correctable, bit 1 uncorrectable, bits 2..5 parity lanes 0..3 (lane i at bit 2+i), and bit 6 address error.
- R3: A write to index 0 clears every cause bit written as one and leaves the bits written as zero unchanged. Writing all ones clears the whole register.
- R4: When an event arrives in the same cycle as a write that clears its cause bit, the bit stays set.
- R5: `fatal_o` is high exactly while any of cause bits 1..6 is set, whatever the enable register holds. A set correctable bit alone never raises it.
- R6: `irq_o` is high in the cycle after a rising edge at which the cause register ANDed with the enable register was nonzero, and low otherwise.
- R7: A correctable event loads its address and five data words into indices 3 (address) and 4..8 (data word 0..4), but only while cause bit 0 is clear. Otherwise the first capture is kept.
- R8: An uncorrectable event loads indices 9 (address) and 10..14 (data word 0..4) under the same rule, using cause bit 1. This is independent of R7.
- R9: Summary bit 0 at index 2 is set one cycle after an edge at which any enabled cause was active. A write of one clears it, but a set condition in the same cycle wins.
- R10: With `LEGACY_CLEAR`=1, a write to the enable register also clears the cause bits written as ones. With `LEGACY_CLEAR`=0, an enable write leaves the cause register untouched.
- R11: The enable register at index 1 stores write bits 6..0 and reads zero above them. The capture registers ignore writes. Index 15 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ce_evt | input | 1 | Correctable error pulse |
| ce_addr | input | 28 | Failing address of the correctable error |
| ce_data | input | 160 | Five data words of the correctable error, word k at bits 32k+31..32k |
| ue_evt | input | 1 | Uncorrectable error pulse |
| ue_addr | input | 28 | Failing address of the uncorrectable error |
| ue_data | input | 160 | Five data words of the uncorrectable error |
| par_evt | input | 4 | Parity error pulse, one bit per lane |
| aerr_evt | input | 1 | Address error pulse |
| irq_o | output | 1 | Registered masked summary interrupt |
| fatal_o | output | 1 | Fatal-error indication |

## Verification
The bench drives two instances, one per clear mode, with the same random mix of event pulses and writes. It also runs directed cases: an event arriving in the same cycle as a clear, a second error arriving while the first capture is still held, an all-ones clear, and an enable write in each mode. A design that gave the clear priority would lose an error. A design that reloaded its capture registers would overwrite the first failing address. One that ignored the mode would either clear causes on an enable write or fail to clear them in legacy mode. Checks on `fatal_o` with only the correctable bit set, and with nothing enabled, catch a fatal line that includes the correctable source or follows the mask.

// File: rtl/memerr_pkg.sv
// Package memerr_pkg
// Shared constants for the memory error interrupt controller: the cause
// register field positions and the register data width.
// Assumes a 32-bit register port.
package memerr_pkg;
    localparam int REG_DW  = 32;   // register data width
    localparam int CE_BIT  = 0;    // correctable error cause bit
    localparam int UE_BIT  = 1;    // uncorrectable error cause bit
    localparam int PAR_LSB = 2;    // first parity lane cause bit

    // Width of the cause register for a given number of parity lanes.
    function automatic int cause_width(input int lanes);
        return lanes + 3;
    endfunction

    // Bit position of the address error cause for a given lane count.
    function automatic int aerr_bit(input int lanes);
        return PAR_LSB + lanes;
    endfunction
endpackage

// File: rtl/memerr_cause_reg.sv
// Module memerr_cause_reg
// Holds the sticky cause register and the enable register. Events set
// cause bits. Write-one-to-clear writes to the cause index clear them, and
// in legacy mode so do writes to the enable index. A set always beats a
// clear in the same cycle.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module memerr_cause_reg
    import memerr_pkg::*;
#(
    parameter int PAR_LANES    = 4,
    parameter int LEGACY_CLEAR = 0,
    localparam int CW          = cause_width(PAR_LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_evt,
    input  logic                 ue_evt,
    input  logic [PAR_LANES-1:0] par_evt,
    input  logic                 aerr_evt,
    input  logic                 cause_wr,
    input  logic                 enable_wr,
    input  logic [CW-1:0]        wdata,
    output logic [CW-1:0]        cause_q,
    output logic [CW-1:0]        enable_q
);
    localparam int AB = aerr_bit(PAR_LANES);

    logic [CW-1:0] set_mask;
    logic [CW-1:0] clr_mask;
    logic          any_evt;

    // Build the set mask from the incoming event pulses.
    always_comb begin
        set_mask                            = '0;
        set_mask[CE_BIT]                    = ce_evt;
        set_mask[UE_BIT]                    = ue_evt;
        set_mask[PAR_LSB +: PAR_LANES]      = par_evt;
        set_mask[AB]                        = aerr_evt;
    end

    assign any_evt = |set_mask;

    // Select the clear sources: the cause write, plus the enable write in legacy mode.
    generate
        if (LEGACY_CLEAR != 0) begin : g_legacy
            always_comb begin
                clr_mask = '0;
                if (cause_wr)  clr_mask = clr_mask | wdata;
                if (enable_wr) clr_mask = clr_mask | wdata;
            end
        end else begin : g_normal
            always_comb begin
                clr_mask = cause_wr ? wdata : '0;
            end
        end
    endgenerate

    // Update the cause register; new events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_mask) | set_mask;
    end

    // Store the enable register on a write to its index.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable_q <= '0;
        else if (enable_wr) enable_q <= wdata;
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_evt || aerr_evt) |=> (cause_q[UE_BIT] || cause_q[AB])); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr && wdata[CE_BIT] && !ce_evt) |=> !cause_q[CE_BIT]); // R3

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr && !enable_wr && (wdata == '0) && !any_evt) |=> $stable(cause_q)); // R3

    generate
        if (LEGACY_CLEAR != 0) begin : g_ast_legacy
            AST_LEGACY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (enable_wr && wdata[UE_BIT] && !ue_evt) |=> !cause_q[UE_BIT]); // R10
        end else begin : g_ast_normal
            AST_ENABLE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
                (enable_wr && !cause_wr && !any_evt) |=> $stable(cause_q)); // R10
        end
    endgenerate
endmodule

// File: rtl/memerr_capture.sv
// Module memerr_capture
// Keeps the failing address and data words of one ECC error class. It
// loads on an event only while the matching cause bit is clear, so the
// first error stays until software clears the cause.
// Assumes held_i is the current (registered) cause bit of this class.
module memerr_capture
    import memerr_pkg::*;
#(
    parameter int ERR_AW = 28,
    parameter int WORDS  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_i,
    input  logic                    held_i,
    input  logic [ERR_AW-1:0]       addr_i,
    input  logic [WORDS*REG_DW-1:0] data_i,
    output logic [ERR_AW-1:0]       addr_q,
    output logic [WORDS*REG_DW-1:0] data_q
);
    logic load;

    assign load = evt_i && !held_i;

    // Latch the failing address on a first error.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= addr_i;
    end

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            // Latch data word w on a first error.
            always_ff @(posedge clk) begin
                if (!rst_n)    data_q[w*REG_DW +: REG_DW] <= '0;
                else if (load) data_q[w*REG_DW +: REG_DW] <= data_i[w*REG_DW +: REG_DW];
            end
        end
    endgenerate

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        held_i |=> ($stable(addr_q) && $stable(data_q))); // R7

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !held_i) |=> (addr_q == $past(addr_i))); // R8
endmodule

// File: rtl/memerr_summary.sv
// Module memerr_summary
// Forms the masked interrupt and the fatal line from the cause and enable
// registers, and keeps the sticky summary bit that the platform clears
// with a write of one.
// Assumes cause bit 0 is the only non-fatal source.
module memerr_summary
    import memerr_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cause_q,
    input  logic [CW-1:0] enable_q,
    input  logic          sum_clr,
    output logic          sum_q,
    output logic          irq_o,
    output logic          fatal_o
);
    logic active;

    assign active = |(cause_q & enable_q);

    // Register the masked interrupt for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= active;
    end

    // Sticky summary bit; the set condition beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= 1'b0;
        else if (active) sum_q <= 1'b1;
        else if (sum_clr) sum_q <= 1'b0;
    end

    // The fatal line covers every source except the correctable one.
    always_comb begin
        fatal_o = |cause_q[CW-1:UE_BIT];
    end

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !irq_o); // R6

    AST_SUMMARY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> sum_q); // R9

    AST_SUMMARY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_q && !sum_clr) |=> sum_q); // R9
endmodule

// File: rtl/memerr_irq_ctrl.sv
// Module memerr_irq_ctrl
// Top of the memory error interrupt controller. It decodes the register
// port, instantiates the cause/enable registers, one capture set for each
// ECC class and the summary logic, and builds the combinational read mux.
// Assumes single-cycle writes and no read side effects.
module memerr_irq_ctrl
    import memerr_pkg::*;
#(
    parameter int PAR_LANES    = 4,
    parameter int ERR_AW       = 28,
    parameter int WORDS        = 5,
    parameter int LEGACY_CLEAR = 0,
    localparam int REG_AW      = $clog2(3 + 2 * (WORDS + 1))
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wen,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [REG_DW-1:0]       reg_wdata,
    output logic [REG_DW-1:0]       reg_rdata,
    input  logic                    ce_evt,
    input  logic [ERR_AW-1:0]       ce_addr,
    input  logic [WORDS*REG_DW-1:0] ce_data,
    input  logic                    ue_evt,
    input  logic [ERR_AW-1:0]       ue_addr,
    input  logic [WORDS*REG_DW-1:0] ue_data,
    input  logic [PAR_LANES-1:0]    par_evt,
    input  logic                    aerr_evt,
    output logic                    irq_o,
    output logic                    fatal_o
);
    localparam int CW      = cause_width(PAR_LANES);
    localparam int IDX_CAU = 0;
    localparam int IDX_EN  = 1;
    localparam int IDX_SUM = 2;
    localparam int IDX_CE  = 3;
    localparam int IDX_UE  = IDX_CE + 1 + WORDS;
    localparam int NREG    = IDX_UE + 1 + WORDS;
    localparam int NCLASS  = 2;

    logic                    cause_wr;
    logic                    enable_wr;
    logic                    sum_clr;
    logic [CW-1:0]           cause_q;
    logic [CW-1:0]           enable_q;
    logic                    sum_q;
    logic [ERR_AW-1:0]       cap_addr [NCLASS];
    logic [WORDS*REG_DW-1:0] cap_data [NCLASS];
    logic [REG_DW-1:0]       rd_tab   [NREG];
    logic                    unused_wdata;

    // Decode the write strobe per register index.
    always_comb begin
        cause_wr  = reg_wen && (reg_addr == REG_AW'(IDX_CAU));
        enable_wr = reg_wen && (reg_addr == REG_AW'(IDX_EN));
        sum_clr   = reg_wen && (reg_addr == REG_AW'(IDX_SUM)) && reg_wdata[0];
    end

    assign unused_wdata = ^reg_wdata[REG_DW-1:CW];

    memerr_cause_reg #(
        .PAR_LANES    (PAR_LANES),
        .LEGACY_CLEAR (LEGACY_CLEAR)
    ) cause_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_evt    (ce_evt),
        .ue_evt    (ue_evt),
        .par_evt   (par_evt),
        .aerr_evt  (aerr_evt),
        .cause_wr  (cause_wr),
        .enable_wr (enable_wr),
        .wdata     (reg_wdata[CW-1:0]),
        .cause_q   (cause_q),
        .enable_q  (enable_q)
    );

    generate
        for (genvar c = 0; c < NCLASS; c++) begin : g_cap
            localparam int BIT = (c == 0) ? CE_BIT : UE_BIT;
            memerr_capture #(
                .ERR_AW (ERR_AW),
                .WORDS  (WORDS)
            ) cap_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt_i  ((c == 0) ? ce_evt  : ue_evt),
                .held_i (cause_q[BIT]),
                .addr_i ((c == 0) ? ce_addr : ue_addr),
                .data_i ((c == 0) ? ce_data : ue_data),
                .addr_q (cap_addr[c]),
                .data_q (cap_data[c])
            );
        end
    endgenerate

    memerr_summary #(
        .CW (CW)
    ) sum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_q  (cause_q),
        .enable_q (enable_q),
        .sum_clr  (sum_clr),
        .sum_q    (sum_q),
        .irq_o    (irq_o),
        .fatal_o  (fatal_o)
    );

    // Fill the control entries of the read table.
    always_comb begin
        rd_tab[IDX_CAU]            = '0;
        rd_tab[IDX_CAU][CW-1:0]    = cause_q;
        rd_tab[IDX_EN]             = '0;
        rd_tab[IDX_EN][CW-1:0]     = enable_q;
        rd_tab[IDX_SUM]            = '0;
        rd_tab[IDX_SUM][0]         = sum_q;
    end

    generate
        for (genvar c = 0; c < NCLASS; c++) begin : g_rd
            localparam int BASE = (c == 0) ? IDX_CE : IDX_UE;
            // Zero-extend the captured address into its read slot.
            always_comb begin
                rd_tab[BASE]             = '0;
                rd_tab[BASE][ERR_AW-1:0] = cap_addr[c];
            end
            for (genvar w = 0; w < WORDS; w++) begin : g_w
                assign rd_tab[BASE + 1 + w] = cap_data[c][w*REG_DW +: REG_DW];
            end
        end
    endgenerate

    // Select read data; indices past the table read zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (reg_addr == REG_AW'(i)) reg_rdata = rd_tab[i];
        end
    end

    AST_FATAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> $past(ue_evt || (|par_evt) || aerr_evt)); // R5

    AST_FATAL_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_evt || aerr_evt) |=> fatal_o); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !fatal_o)); // R1
endmodule

// File: tb/memerr_irq_ctrl_tb_top.sv
module memerr_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int AW    = 28;
    localparam int WDS   = 5;
    localparam int CW    = LANES + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wen = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic ce_evt = 1'b0, ue_evt = 1'b0, aerr_evt = 1'b0;
    logic [AW-1:0] ce_addr = '0, ue_addr = '0;
    logic [WDS*32-1:0] ce_data = '0, ue_data = '0;
    logic [LANES-1:0] par_evt = '0;
    logic [31:0] rdata [2];
    logic irq [2];
    logic fatal [2];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state, index 0 = normal mode, 1 = legacy mode.
    logic [CW-1:0] m_cause [2];
    logic [CW-1:0] m_en [2];
    logic m_sum [2];
    logic m_irq [2];
    logic [31:0] m_cap [2][2][WDS+1];

    always #(CLK_PERIOD/2) clk = ~clk;

    memerr_irq_ctrl #(.LEGACY_CLEAR(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata[0]), .ce_evt(ce_evt),
        .ce_addr(ce_addr), .ce_data(ce_data), .ue_evt(ue_evt), .ue_addr(ue_addr),
        .ue_data(ue_data), .par_evt(par_evt), .aerr_evt(aerr_evt),
        .irq_o(irq[0]), .fatal_o(fatal[0]));

    memerr_irq_ctrl #(.LEGACY_CLEAR(1)) dut_lg_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata[1]), .ce_evt(ce_evt),
        .ce_addr(ce_addr), .ce_data(ce_data), .ue_evt(ue_evt), .ue_addr(ue_addr),
        .ue_data(ue_data), .par_evt(par_evt), .aerr_evt(aerr_evt),
        .irq_o(irq[1]), .fatal_o(fatal[1]));

    task automatic chk(input string req, input int m, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s mode=%0d actual=%h expected=%h at %0t", req, m, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rd_model(input int m, input logic [3:0] a);
        logic [31:0] v = '0;
        if (a == 0) v[CW-1:0] = m_cause[m];
        else if (a == 1) v[CW-1:0] = m_en[m];
        else if (a == 2) v[0] = m_sum[m];
        else if (a >= 3 && a <= 8) v = m_cap[m][0][a-3];
        else if (a >= 9 && a <= 14) v = m_cap[m][1][a-9];
        return v;
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        if (a == 0) return "R2";
        if (a == 1) return "R11";
        if (a == 2) return "R9";
        if (a <= 8) return "R7";
        if (a <= 14) return "R8";
        return "R11";
    endfunction

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            m_cause[m] = '0; m_en[m] = '0; m_sum[m] = 1'b0; m_irq[m] = 1'b0;
            for (int c = 0; c < 2; c++)
                for (int w = 0; w <= WDS; w++) m_cap[m][c][w] = '0;
        end
    endtask

    // Apply one clock edge of the requirement rules to the reference state.
    task automatic model_edge();
        logic [CW-1:0] setm, clr;
        logic act;
        setm = {aerr_evt, par_evt, ue_evt, ce_evt};
        for (int m = 0; m < 2; m++) begin
            clr = '0;
            if (reg_wen && reg_addr == 0) clr = reg_wdata[CW-1:0];
            if (m == 1 && reg_wen && reg_addr == 1) clr = clr | reg_wdata[CW-1:0];
            act = |(m_cause[m] & m_en[m]);
            if (ce_evt && !m_cause[m][0]) begin
                m_cap[m][0][0] = 32'(ce_addr);
                for (int w = 0; w < WDS; w++) m_cap[m][0][w+1] = ce_data[w*32 +: 32];
            end
            if (ue_evt && !m_cause[m][1]) begin
                m_cap[m][1][0] = 32'(ue_addr);
                for (int w = 0; w < WDS; w++) m_cap[m][1][w+1] = ue_data[w*32 +: 32];
            end
            m_sum[m] = act | (m_sum[m] & ~(reg_wen && reg_addr == 2 && reg_wdata[0]));
            m_irq[m] = act;
            m_cause[m] = (m_cause[m] & ~clr) | setm;
            if (reg_wen && reg_addr == 1) m_en[m] = reg_wdata[CW-1:0];
        end
    endtask

    // Check outputs against the model, then run one edge and clear the pulses.
    task automatic tick(input string tag);
        #1;
        for (int m = 0; m < 2; m++) begin
            chk(tag == "" ? "R5" : tag, m, 32'(fatal[m]), 32'(|m_cause[m][CW-1:1]));
            chk(tag == "" ? "R6" : tag, m, 32'(irq[m]), 32'(m_irq[m]));
            if (!reg_wen) chk(tag == "" ? tag_for(reg_addr) : tag, m, rdata[m], rd_model(m, reg_addr));
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        reg_wen = 1'b0; ce_evt = 1'b0; ue_evt = 1'b0; par_evt = '0; aerr_evt = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d; tick(tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        reg_wen = 1'b0; reg_addr = a; tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every index reads zero after reset
        for (int a = 0; a < 16; a++) rd(4'(a), "R1");
        #1;
        chk("R1", 0, 32'(irq[0] | fatal[0]), 32'h0);

        // R2: each event sets its own bit
        ce_evt = 1'b1; ce_addr = 28'h0AB_CDEF; ce_data = {5{32'h1111_2222}}; rd(0, "R2");
        rd(0, "R2");
        #1; chk("R2", 0, rdata[0], 32'h01);
        chk("R5", 0, 32'(fatal[0]), 32'h0);   // correctable alone is not fatal
        par_evt = 4'b0100; rd(0, "R2");
        rd(0, "R2");
        #1; chk("R2", 0, rdata[0], 32'h11);
        chk("R5", 0, 32'(fatal[0]), 32'h1);   // parity is fatal with nothing enabled
        // R7: second correctable event must not overwrite the capture
        ce_evt = 1'b1; ce_addr = 28'h123_4567; ce_data = {5{32'hDEAD_BEEF}}; rd(3, "R7");
        rd(3, "R7");
        #1; chk("R7", 0, rdata[0], 32'h0AB_CDEF);
        rd(5, "R7");
        // R3: writing zero keeps everything, all ones clears all
        wr(0, 32'h0, "R3");
        rd(0, "R3");
        wr(0, 32'hFFFF_FFFF, "R3");
        rd(0, "R3");
        #1; chk("R3", 0, rdata[0], 32'h0);
        // R8: uncorrectable capture
        ue_evt = 1'b1; ue_addr = 28'hFED_CBA9; ue_data = {32'h5, 32'h4, 32'h3, 32'h2, 32'h1}; rd(9, "R8");
        for (int a = 9; a <= 14; a++) rd(4'(a), "R8");
        // R4: clear and event in the same cycle
        reg_wen = 1'b1; reg_addr = 0; reg_wdata = 32'h2; ue_evt = 1'b1; ue_addr = 28'h1; tick("R4");
        rd(0, "R4");
        #1; chk("R4", 0, rdata[0], 32'h2);
        rd(9, "R4");
        // R11: enable stores only the low bits
        wr(1, 32'hFFFF_FF02, "R11");
        rd(1, "R11");
        #1; chk("R11", 0, rdata[0], 32'h02);
        // R10: the enable write cleared the uncorrectable bit only in legacy mode
        rd(0, "R10");
        #1; chk("R10", 0, rdata[0], 32'h02); chk("R10", 1, rdata[1], 32'h00);
        // R6 and R9: enabled cause drives irq and summary
        ue_evt = 1'b1; rd(2, "R6");
        rd(2, "R6"); rd(2, "R9");
        wr(2, 32'h1, "R9");   // clear while still active: stays set
        rd(2, "R9");
        wr(0, 32'hFF, "R9");
        rd(2, "R9"); wr(2, 32'h1, "R9"); rd(2, "R9");
        #1; chk("R9", 0, rdata[0], 32'h0);
        // R11: writes to capture and unmapped indices do nothing
        wr(9, 32'hFFFF_FFFF, "R11"); wr(15, 32'hFFFF_FFFF, "R11");
        rd(9, "R11"); rd(15, "R11");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            ce_evt = ($urandom % 8) == 0;
            ue_evt = ($urandom % 10) == 0;
            par_evt = (($urandom % 12) == 0) ? 4'($urandom) : 4'h0;
            aerr_evt = ($urandom % 14) == 0;
            ce_addr = 28'($urandom); ue_addr = 28'($urandom);
            for (int w = 0; w < WDS; w++) begin
                ce_data[w*32 +: 32] = $urandom; ue_data[w*32 +: 32] = $urandom;
            end
            reg_addr = 4'($urandom);
            reg_wen = ($urandom % 4) == 0;
            if (reg_wen) begin
                reg_addr = 4'($urandom % 3);
                reg_wdata = (($urandom % 3) == 0) ? 32'hFFFF_FFFF : $urandom;
            end
            tick("");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule